// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame is taken or dropped, and says whether it was taken as broadcast or as multicast. It looks at three things: the first six bytes of the frame (the destination address), the frame length without the frame check sequence, and four acceptance-mode inputs. A 16-entry table of 48-bit station addresses, each gated by one bit of a 16-bit enable mask, supplies the exact-match addresses.

The receive path streams the address bytes in with a start marker on the first byte and an end marker that carries the length. The filter captures the first six bytes and ignores the rest. Once the end marker is seen, the filter takes one cycle to decide and presents the result as a one-cycle pulse. The address table is written one entry at a time through a direct load port. While the controller is held in its reset mode, the table can be read back one 16-bit word at a time. Fetching table contents from memory is left to the surrounding controller.

The checks run in a fixed order, and the first one that applies settles the frame: runt, then promiscuous (non-group frames only), then accept-all-multicast, then broadcast, then the enabled table entries.

Top module: `rx_addr_filter`

## Requirements
- R1: For every cycle in which `fr_end` is high (cycle T), `dec_valid` is high in cycle T+2 only; in every other cycle `dec_valid`, `dec_accept`, `dec_bcast` and `dec_mcast` are all low.
- R2: A frame is a runt when `fr_len` at the end marker is below 60, or when fewer than six address bytes arrived up to and including the end-marker cycle. A runt is accepted, with both class flags low, exactly when `mode_runt_ok` is high, and is rejected otherwise; no later check applies to it.
- R3: For a frame that is not a runt, with `mode_promisc` high and bit 0 of the first address byte clear, the frame is accepted with both class flags low.
- R4: For a frame that is not a runt and that R3 did not accept, with `mode_all_mcast` high and bit 0 of the first address byte set, the frame is accepted with `dec_mcast` high. This includes the all-ones address.
- R5: For a frame that R2 to R4 did not settle, with `mode_bcast_ok` high and all 48 address bits set, the frame is accepted with `dec_bcast` high.
- R6: Otherwise the frame is accepted, with both class flags low, exactly when the address equals a table entry whose mask bit is set. An entry whose mask bit is clear never matches.
- R7: A frame that no earlier rule accepts is rejected. After reset the table and the mask are all zero and every output is low.
- R8: A table or mask write takes effect at the clock edge on which it is presented. A frame whose decision cycle follows that edge sees the new contents. Table byte k of `cam_wdata` sits in bits 8k+7:8k, and byte 0 is compared with the first address byte.
- R9: When `cfg_reset_mode` is high, `cam_rd_data` in the next cycle returns word w (0 to 2) of the entry selected by the low four bits of `cam_rd_ptr`, as {byte 2w+1, byte 2w}. Word select 3 returns zero.
- R10: When `cfg_reset_mode` is low, `cam_rd_data` in the next cycle is zero.
- R11: Address bytes after the sixth are ignored. A `fr_start` restarts capture with the byte presented in the same cycle as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_start | input | 1 | First byte of a frame (with `fr_byte_vld`) |
| fr_byte_vld | input | 1 | `fr_byte` carries an address byte |
| fr_byte | input | 8 | Address byte in arrival order |
| fr_end | input | 1 | End marker; `fr_len` valid this cycle |
| fr_len | input | 16 | Frame length in bytes without FCS |
| mode_runt_ok | input | 1 | Accept runt frames |
| mode_promisc | input | 1 | Accept every non-group frame |
| mode_all_mcast | input | 1 | Accept every group frame as multicast |
| mode_bcast_ok | input | 1 | Accept the all-ones address as broadcast |
| cam_we | input | 1 | Write one table entry |
| cam_widx | input | 4 | Entry index to write |
| cam_wdata | input | 48 | Entry contents, byte k in bits 8k+7:8k |
| cam_mask_we | input | 1 | Write the enable mask |
| cam_mask_wdata | input | 16 | Enable mask, bit i enables entry i |
| cfg_reset_mode | input | 1 | Controller in reset mode; enables read-back |
| cam_rd_ptr | input | 8 | Entry pointer; low four bits select the entry |
| cam_rd_word | input | 2 | Word of the entry to read back |
| cam_rd_data | output | 16 | Read-back word, one cycle after the request |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_bcast | output | 1 | Accepted as broadcast |
| dec_mcast | output | 1 | Accepted as multicast |

## Verification
The bench aims at the places where the priority order matters. A broadcast frame with all-multicast enabled must be flagged as multicast; a design that checked broadcast first would raise the wrong flag. A broadcast runt must be rejected even with broadcast acceptance on; a design that did not stop at the runt check would accept it. A frame of exactly 60 bytes, and one that ends after four address bytes but claims a long length, probe the runt boundary; getting either wrong flips the accept flag. Disabled entries, entries rewritten just before a decision, read-back pointers with their upper bits set, and frames with trailing bytes or a restarted start would each show up as a wrong accept flag or wrong read-back data. Back-to-back end markers must yield back-to-back pulses rather than a merged or dropped decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Smallest frame length, FCS excluded, that is not a runt
    localparam int MIN_FRAME_LEN = 60;

    typedef struct packed {
        logic valid;
        logic accept;
        logic bcast;
        logic mcast;
    } rxf_dec_t;

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
    parameter int ADDR_BYTES = 6,
    parameter int LEN_W      = 16,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_start,
    input  logic              fr_byte_vld,
    input  logic [7:0]        fr_byte,
    input  logic              fr_end,
    input  logic [LEN_W-1:0]  fr_len,
    output logic [ADDR_W-1:0] dest_addr,
    output logic              end_pend,
    output logic              end_short,
    output logic [LEN_W-1:0]  end_len
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic              short_addr;
        logic [LEN_W-1:0]  len;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        base_cnt  = fr_start ? '0 : st_q.cnt;
        next_cnt  = base_cnt;
        if (fr_byte_vld && (base_cnt < CNT_W'(ADDR_BYTES))) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (base_cnt == CNT_W'(b)) begin
                    st_d.addr[b*8 +: 8] = fr_byte;
                end
            end
            next_cnt = base_cnt + 1'b1;
        end
        if (fr_end) begin
            st_d.pend       = 1'b1;
            st_d.short_addr = (next_cnt < CNT_W'(ADDR_BYTES));
            st_d.len        = fr_len;
            st_d.cnt        = '0;
        end else begin
            st_d.cnt        = next_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dest_addr = st_q.addr;
    assign end_pend  = st_q.pend;
    assign end_short = st_q.short_addr;
    assign end_len   = st_q.len;

endmodule

// File: rtl/rxf_cam.sv
module rxf_cam #(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_BYTES  = 6,
    parameter int PTR_W       = 8,
    localparam int ADDR_W     = ADDR_BYTES * 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int WORDS      = ADDR_BYTES / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic                   mask_wr_en,
    input  logic [NUM_ENTRIES-1:0] mask_wr_data,
    input  logic [ADDR_W-1:0]      cmp_addr,
    output logic                   hit,
    input  logic                   rd_mode,
    input  logic [PTR_W-1:0]       rd_ptr,
    input  logic [1:0]             rd_word,
    output logic [15:0]            rd_data
);

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent;
        logic [NUM_ENTRIES-1:0]             mask;
        logic [15:0]                        rd;
    } cam_st_t;

    cam_st_t st_d, st_q;
    logic [NUM_ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]       rd_sel;

    // All entries compared in parallel against the captured address
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
        assign match_vec[e] = st_q.mask[e] && (st_q.ent[e] == cmp_addr);
    end

    assign hit    = |match_vec;
    assign rd_sel = IDX_W'(rd_ptr % PTR_W'(NUM_ENTRIES));

    always_comb begin
        st_d    = st_q;
        st_d.rd = '0;
        if (rd_mode) begin
            for (int w = 0; w < WORDS; w++) begin
                if (rd_word == 2'(w)) begin
                    st_d.rd = st_q.ent[rd_sel][w*16 +: 16];
                end
            end
        end
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_addr;
        end
        if (mask_wr_en) begin
            st_d.mask = mask_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = MIN_FRAME_LEN,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic              short_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cam_hit,
    input  logic              mode_runt_ok,
    input  logic              mode_promisc,
    input  logic              mode_all_mcast,
    input  logic              mode_bcast_ok,
    output rxf_dec_t          dec
);

    rxf_dec_t dec_d, dec_q;
    logic     is_runt;
    logic     is_group;
    logic     is_bcast;

    assign is_runt  = short_addr || (len < LEN_W'(MIN_LEN));
    assign is_group = addr[0];
    assign is_bcast = &addr;

    // First applicable rule wins
    always_comb begin
        dec_d       = '0;
        dec_d.valid = pend;
        if (pend) begin
            if (is_runt) begin
                dec_d.accept = mode_runt_ok;
            end else if (mode_promisc && !is_group) begin
                dec_d.accept = 1'b1;
            end else if (mode_all_mcast && is_group) begin
                dec_d.accept = 1'b1;
                dec_d.mcast  = 1'b1;
            end else if (mode_bcast_ok && is_bcast) begin
                dec_d.accept = 1'b1;
                dec_d.bcast  = 1'b1;
            end else begin
                dec_d.accept = cam_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec = dec_q;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_BYTES  = 6,
    parameter int LEN_W       = 16,
    parameter int PTR_W       = 8,
    parameter int MIN_LEN     = MIN_FRAME_LEN,
    localparam int ADDR_W     = ADDR_BYTES * 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fr_start,
    input  logic                   fr_byte_vld,
    input  logic [7:0]             fr_byte,
    input  logic                   fr_end,
    input  logic [LEN_W-1:0]       fr_len,
    input  logic                   mode_runt_ok,
    input  logic                   mode_promisc,
    input  logic                   mode_all_mcast,
    input  logic                   mode_bcast_ok,
    input  logic                   cam_we,
    input  logic [IDX_W-1:0]       cam_widx,
    input  logic [ADDR_W-1:0]      cam_wdata,
    input  logic                   cam_mask_we,
    input  logic [NUM_ENTRIES-1:0] cam_mask_wdata,
    input  logic                   cfg_reset_mode,
    input  logic [PTR_W-1:0]       cam_rd_ptr,
    input  logic [1:0]             cam_rd_word,
    output logic [15:0]            cam_rd_data,
    output logic                   dec_valid,
    output logic                   dec_accept,
    output logic                   dec_bcast,
    output logic                   dec_mcast
);

    logic [ADDR_W-1:0] dest_addr;
    logic              end_pend;
    logic              end_short;
    logic [LEN_W-1:0]  end_len;
    logic              cam_hit;
    rxf_dec_t          dec;

    rxf_addr_capture #(
        .ADDR_BYTES (ADDR_BYTES),
        .LEN_W      (LEN_W)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .fr_start    (fr_start),
        .fr_byte_vld (fr_byte_vld),
        .fr_byte     (fr_byte),
        .fr_end      (fr_end),
        .fr_len      (fr_len),
        .dest_addr   (dest_addr),
        .end_pend    (end_pend),
        .end_short   (end_short),
        .end_len     (end_len)
    );

    rxf_cam #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_BYTES  (ADDR_BYTES),
        .PTR_W       (PTR_W)
    ) u_cam (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cam_we),
        .wr_idx       (cam_widx),
        .wr_addr      (cam_wdata),
        .mask_wr_en   (cam_mask_we),
        .mask_wr_data (cam_mask_wdata),
        .cmp_addr     (dest_addr),
        .hit          (cam_hit),
        .rd_mode      (cfg_reset_mode),
        .rd_ptr       (cam_rd_ptr),
        .rd_word      (cam_rd_word),
        .rd_data      (cam_rd_data)
    );

    rxf_decide #(
        .ADDR_BYTES (ADDR_BYTES),
        .LEN_W      (LEN_W),
        .MIN_LEN    (MIN_LEN)
    ) u_decide (
        .clk            (clk),
        .rst_n          (rst_n),
        .pend           (end_pend),
        .short_addr     (end_short),
        .len            (end_len),
        .addr           (dest_addr),
        .cam_hit        (cam_hit),
        .mode_runt_ok   (mode_runt_ok),
        .mode_promisc   (mode_promisc),
        .mode_all_mcast (mode_all_mcast),
        .mode_bcast_ok  (mode_bcast_ok),
        .dec            (dec)
    );

    assign dec_valid  = dec.valid;
    assign dec_accept = dec.accept;
    assign dec_bcast  = dec.bcast;
    assign dec_mcast  = dec.mcast;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fr_end,
    input logic [LEN_W-1:0] fr_len,
    input logic             cfg_reset_mode,
    input logic [15:0]      cam_rd_data,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_bcast,
    input logic             dec_mcast
);

    // R1: every end marker yields a decision two cycles later
    a_r1_end_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fr_end |=> ##1 dec_valid);

    // R1: no decision without an end marker two cycles earlier
    a_r1_pulse_has_end: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(fr_end, 2));

    // R1: outputs quiet outside the decision pulse
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_accept || dec_bcast || dec_mcast));

    // R4 / R5: at most one class flag, and only on an accepted frame
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_bcast || dec_mcast) |-> (dec_accept && !(dec_bcast && dec_mcast)));

    // R2: a short length never carries a class flag
    a_r2_runt_no_class: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fr_end, 2) && ($past(fr_len, 2) < LEN_W'(MIN_LEN)))
            |-> (dec_valid && !dec_bcast && !dec_mcast));

    // R10: read-back is zero outside reset mode
    a_r10_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_reset_mode |=> (cam_rd_data == 16'h0000));

endmodule

bind rx_addr_filter rxf_checker #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN)
) u_rxf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fr_end         (fr_end),
    .fr_len         (fr_len),
    .cfg_reset_mode (cfg_reset_mode),
    .cam_rd_data    (cam_rd_data),
    .dec_valid      (dec_valid),
    .dec_accept     (dec_accept),
    .dec_bcast      (dec_bcast),
    .dec_mcast      (dec_mcast)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_start = 1'b0, fr_byte_vld = 1'b0, fr_end = 1'b0;
    logic [7:0]  fr_byte = '0;
    logic [15:0] fr_len = '0;
    logic        mode_runt_ok = 1'b0, mode_promisc = 1'b0;
    logic        mode_all_mcast = 1'b0, mode_bcast_ok = 1'b0;
    logic        cam_we = 1'b0, cam_mask_we = 1'b0;
    logic [3:0]  cam_widx = '0;
    logic [47:0] cam_wdata = '0;
    logic [15:0] cam_mask_wdata = '0;
    logic        cfg_reset_mode = 1'b0;
    logic [7:0]  cam_rd_ptr = '0;
    logic [1:0]  cam_rd_word = '0;
    logic [15:0] cam_rd_data;
    logic        dec_valid, dec_accept, dec_bcast, dec_mcast;

    always #5 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .fr_start(fr_start), .fr_byte_vld(fr_byte_vld), .fr_byte(fr_byte),
        .fr_end(fr_end), .fr_len(fr_len),
        .mode_runt_ok(mode_runt_ok), .mode_promisc(mode_promisc),
        .mode_all_mcast(mode_all_mcast), .mode_bcast_ok(mode_bcast_ok),
        .cam_we(cam_we), .cam_widx(cam_widx), .cam_wdata(cam_wdata),
        .cam_mask_we(cam_mask_we), .cam_mask_wdata(cam_mask_wdata),
        .cfg_reset_mode(cfg_reset_mode), .cam_rd_ptr(cam_rd_ptr),
        .cam_rd_word(cam_rd_word), .cam_rd_data(cam_rd_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_bcast(dec_bcast), .dec_mcast(dec_mcast)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R7";
    bit    done = 1'b0;

    // ---------------- behavioural reference ----------------
    byte unsigned m_tab [16][6];
    bit          m_en  [16];
    byte unsigned m_da  [6];
    int          m_cnt = 0;
    bit          m_pend = 0, m_short = 0;
    int          m_len = 0;
    logic        x_v = 0, x_a = 0, x_b = 0, x_m = 0;
    logic [15:0] x_rd = '0;

    function automatic bit da_is(byte unsigned v [6], byte unsigned w [6]);
        for (int k = 0; k < 6; k++) if (v[k] != w[k]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_en[i] = 0;
                for (int k = 0; k < 6; k++) m_tab[i][k] = 8'h00;
            end
            for (int k = 0; k < 6; k++) m_da[k] = 8'h00;
            m_cnt = 0; m_pend = 0; m_short = 0; m_len = 0;
            x_v = 0; x_a = 0; x_b = 0; x_m = 0; x_rd = '0;
        end else begin
            bit all_ff;
            x_v = m_pend; x_a = 0; x_b = 0; x_m = 0;
            if (m_pend) begin
                all_ff = 1'b1;
                for (int k = 0; k < 6; k++) if (m_da[k] != 8'hff) all_ff = 1'b0;
                if (m_short || m_len < 60) x_a = mode_runt_ok;
                else if (mode_promisc && !m_da[0][0]) x_a = 1;
                else if (mode_all_mcast && m_da[0][0]) begin x_a = 1; x_m = 1; end
                else if (mode_bcast_ok && all_ff) begin x_a = 1; x_b = 1; end
                else for (int i = 0; i < 16; i++)
                    if (m_en[i] && da_is(m_tab[i], m_da)) x_a = 1;
            end
            x_rd = '0;
            if (cfg_reset_mode && cam_rd_word != 2'd3)
                x_rd = {m_tab[cam_rd_ptr % 16][2*cam_rd_word+1],
                        m_tab[cam_rd_ptr % 16][2*cam_rd_word]};
            if (cam_we)
                for (int k = 0; k < 6; k++) m_tab[cam_widx][k] = cam_wdata[8*k +: 8];
            if (cam_mask_we)
                for (int i = 0; i < 16; i++) m_en[i] = cam_mask_wdata[i];
            if (fr_start) m_cnt = 0;
            if (fr_byte_vld && m_cnt < 6) begin m_da[m_cnt] = fr_byte; m_cnt++; end
            if (fr_end) begin
                m_pend = 1; m_short = (m_cnt < 6); m_len = int'(fr_len); m_cnt = 0;
            end else m_pend = 0;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if ({dec_valid, dec_accept, dec_bcast, dec_mcast} !== {x_v, x_a, x_b, x_m}) begin
                n_bad++;
                $display("FAIL %s: dec v/a/b/m actual %b%b%b%b expected %b%b%b%b at %0t",
                    cur_req, dec_valid, dec_accept, dec_bcast, dec_mcast,
                    x_v, x_a, x_b, x_m, $time);
            end
            if (cam_rd_data !== x_rd) begin
                n_bad++;
                $display("FAIL %s: cam_rd_data actual %h expected %h at %0t",
                    cur_req, cam_rd_data, x_rd, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fr_start = 0; fr_byte_vld = 0; fr_end = 0;
            cam_we = 0; cam_mask_we = 0;
        end
    endtask

    task automatic send_frame(input logic [47:0] da, input int nb, input int len,
                              input bit sep_end);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            fr_start = (i == 0); fr_byte_vld = 1;
            fr_byte = (i < 6) ? da[8*i +: 8] : 8'($urandom);
            fr_end = (!sep_end && i == nb - 1);
            fr_len = 16'(len);
        end
        if (sep_end || nb == 0) begin
            @(negedge clk);
            fr_start = 0; fr_byte_vld = 0; fr_end = 1; fr_len = 16'(len);
        end
        idle(1);
    endtask

    task automatic set_mode(input bit r, input bit p, input bit am, input bit bc);
        @(negedge clk);
        mode_runt_ok = r; mode_promisc = p; mode_all_mcast = am; mode_bcast_ok = bc;
    endtask

    function automatic logic [47:0] tab_addr(input int i);
        return {8'(i * 3), 8'(i), 8'h10, 8'h5e, 8'h00, 8'h02};
    endfunction

    task automatic write_entry(input int i, input logic [47:0] a);
        @(negedge clk);
        cam_we = 1; cam_widx = 4'(i); cam_wdata = a;
        @(negedge clk);
        cam_we = 0;
    endtask

    task automatic write_mask(input logic [15:0] m);
        @(negedge clk);
        cam_mask_we = 1; cam_mask_wdata = m;
        @(negedge clk);
        cam_mask_we = 0;
    endtask

    task automatic readback(input logic [7:0] p, input logic [1:0] w);
        @(negedge clk);
        cam_rd_ptr = p; cam_rd_word = w;
        idle(1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7: reset state
        cur_req = "R7";
        idle(3);

        // R8: load table, enable entries 0..7
        cur_req = "R8";
        for (int i = 0; i < 16; i++) write_entry(i, tab_addr(i));
        write_mask(16'h00ff);

        // R9: read-back in reset mode
        cur_req = "R9";
        cfg_reset_mode = 1;
        readback(8'h03, 2'd0);
        readback(8'h03, 2'd1);
        readback(8'ha3, 2'd2);
        readback(8'hff, 2'd1);
        readback(8'h05, 2'd3);
        // R10: read-back outside reset mode
        cur_req = "R10";
        @(negedge clk); cfg_reset_mode = 0;
        readback(8'h03, 2'd0);
        readback(8'h07, 2'd2);

        // R6: enabled and disabled entries
        cur_req = "R6";
        set_mode(0, 0, 0, 0);
        send_frame(tab_addr(3), 6, 64, 0);
        idle(2);
        send_frame(tab_addr(10), 8, 64, 0);
        idle(2);
        // R7: no match
        cur_req = "R7";
        send_frame(48'h665544332210, 6, 64, 0);
        idle(2);

        // R2: runt rules and boundary
        cur_req = "R2";
        send_frame(tab_addr(3), 6, 59, 0);
        idle(2);
        send_frame(tab_addr(3), 6, 60, 0);
        idle(2);
        set_mode(0, 0, 0, 1);
        send_frame(48'hffffffffffff, 6, 40, 0);
        idle(2);
        set_mode(1, 0, 0, 1);
        send_frame(48'hffffffffffff, 6, 40, 1);
        idle(2);
        set_mode(0, 0, 0, 0);
        send_frame(tab_addr(3), 4, 100, 0);
        idle(2);
        set_mode(1, 0, 0, 0);
        send_frame(tab_addr(3), 4, 100, 1);
        idle(2);

        // R3: promiscuous
        cur_req = "R3";
        set_mode(0, 1, 0, 0);
        send_frame(48'h123456789a00, 6, 64, 0);
        idle(2);
        send_frame(48'h123456789a01, 6, 64, 0);
        idle(2);

        // R4: all multicast, including broadcast
        cur_req = "R4";
        set_mode(0, 0, 1, 1);
        send_frame(48'h0a000a5e0001, 6, 64, 0);
        idle(2);
        send_frame(48'hffffffffffff, 6, 64, 0);
        idle(2);

        // R5: broadcast only
        cur_req = "R5";
        set_mode(0, 0, 0, 1);
        send_frame(48'hffffffffffff, 6, 64, 0);
        idle(2);
        send_frame(48'hfeffffffffff, 6, 64, 0);
        idle(2);

        // R8: mask and entry rewrites take effect
        cur_req = "R8";
        set_mode(0, 0, 0, 0);
        write_mask(16'h04ff);
        send_frame(tab_addr(10), 6, 64, 0);
        idle(2);
        write_entry(3, 48'h0000aa0000cc);
        send_frame(tab_addr(3), 6, 64, 0);
        idle(2);
        send_frame(48'h0000aa0000cc, 6, 64, 0);
        idle(2);

        // R11: trailing bytes ignored, start restarts capture
        cur_req = "R11";
        send_frame(tab_addr(5), 12, 64, 0);
        idle(2);
        send_frame(48'h0000000000cc, 3, 64, 1);
        idle(1);
        send_frame(tab_addr(6), 6, 64, 0);
        idle(2);

        // R1: back-to-back end markers
        cur_req = "R1";
        @(negedge clk);
        fr_start = 1; fr_byte_vld = 1; fr_byte = 8'h01; fr_end = 1; fr_len = 16'd70;
        @(negedge clk);
        fr_start = 1; fr_byte_vld = 1; fr_byte = 8'h02; fr_end = 1; fr_len = 16'd30;
        @(negedge clk);
        fr_start = 0; fr_byte_vld = 0; fr_end = 1; fr_len = 16'd80;
        idle(4);

        // R1: randomized mix against the reference
        for (int n = 0; n < 400; n++) begin
            int pick;
            logic [47:0] a;
            pick = $urandom_range(0, 4);
            case (pick)
                0: a = tab_addr($urandom_range(0, 15));
                1: a = 48'hffffffffffff;
                2: a = {$urandom, 16'($urandom)} | 48'h1;
                default: a = {$urandom, 16'($urandom)};
            endcase
            @(negedge clk);
            mode_runt_ok = 1'($urandom); mode_promisc = 1'($urandom);
            mode_all_mcast = 1'($urandom); mode_bcast_ok = 1'($urandom);
            cfg_reset_mode = 1'($urandom); cam_rd_ptr = 8'($urandom);
            cam_rd_word = 2'($urandom);
            if ($urandom_range(0, 9) == 0) begin
                cam_mask_we = 1; cam_mask_wdata = 16'($urandom);
            end
            send_frame(a, $urandom_range(2, 9), $urandom_range(55, 66),
                       1'($urandom));
            idle($urandom_range(0, 2));
        end
        idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule